// File: doc/BRIEF.md
# Tile-to-Router Port Concentrator

This block lets a group of tiles share a single router port. Each tile has its own valid/ready stream in each direction, and so does the router port. On the outbound side, a rotating scan picks one tile with a pending word and passes it to the router. The word is first widened with the index of the tile it came from. On the inbound side, each packet from the router carries a tile-select field in its top bits. The block removes that field and places the remaining payload in the holding register of the named tile. A select value that names no attached tile is discarded, and the block raises a one-cycle error pulse.

Each direction holds the packet in exactly one register stage, so a packet crosses the block in one cycle. The tile count and the tile word width are parameters. The select field is `$clog2(N_TILES)` bits wide: 1 bit for two tiles, 2 bits for four, 4 bits for sixteen. The block assumes the combined tile traffic fits within the port rate, so it does no rate policing.

Top module: `tile_port_concentrator`

## Requirements
- R1: An outbound packet is `PKT_W = DATA_W + SEL_W` bits wide. Bits `[PKT_W-1:DATA_W]` carry the index of the source tile, and bits `[DATA_W-1:0]` carry that tile's word unchanged.
- R2: When the output stage can load, at most one tile is granted per cycle. The grant (`tile_tx_ready_o` bit) goes to the first requesting tile at or after the rotation pointer, counting upward and wrapping. After a grant to tile g, the pointer becomes (g+1) mod N_TILES.
- R3: In a cycle with no requesting tile, no grant is given and the rotation pointer keeps its value.
- R4: A word granted at a clock edge appears on `rtr_tx_valid_o`/`rtr_tx_data_o` from that edge on. The stage may load again in the cycle it is drained. While `rtr_tx_ready_i` is low, the valid output and the data stay unchanged.
- R5: An accepted inbound packet whose select field s is below N_TILES appears after one edge on tile s only. That tile sees its `tile_rx_valid_o` bit set and receives data bits `[DATA_W-1:0]` of the packet.
- R6: Each tile output holds one packet until that tile's ready is high. `rtr_rx_ready_o` is low exactly when the packet's selected tile holds a packet and that tile is not ready. Packets are neither dropped nor reordered.
- R7: A packet whose select field is N_TILES or more is always accepted. It changes no tile output, and `err_o` is high in the following cycle only.
- R8: While `rst_ni` is low, all output valids and `err_o` are low and the rotation pointer is 0. The first grant with every tile requesting therefore goes to tile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tile_tx_valid_i | input | N_TILES | Per-tile outbound request |
| tile_tx_data_i | input | N_TILES*DATA_W | Per-tile outbound word, tile t at `[t*DATA_W +: DATA_W]` |
| tile_tx_ready_o | output | N_TILES | Per-tile grant |
| rtr_tx_valid_o | output | 1 | Packet valid toward router |
| rtr_tx_data_o | output | PKT_W | Packet toward router |
| rtr_tx_ready_i | input | 1 | Router accepts packet |
| rtr_rx_valid_i | input | 1 | Packet valid from router |
| rtr_rx_data_i | input | PKT_W | Packet from router, select in top SEL_W bits |
| rtr_rx_ready_o | output | 1 | Block accepts router packet |
| tile_rx_valid_o | output | N_TILES | Per-tile inbound valid |
| tile_rx_data_o | output | N_TILES*DATA_W | Per-tile inbound word |
| tile_rx_ready_i | input | N_TILES | Per-tile inbound ready |
| err_o | output | 1 | One-cycle pulse for a dropped bad-select packet |

## Verification
The default build has six tiles, so the 3-bit select field has two unused codes. The bench first drives every tile requesting with the router always ready. This separates true rotation from fixed priority and also confirms the tile-0 start after reset. Idle stretches show whether the pointer drifts when nothing is granted. Sparse requests combined with router stalls expose a stage that drops or overwrites a held word. On the inbound side, slow tile readies with dense traffic check that the block stalls only for a busy target. A mix rich in the unused select codes checks that such packets are dropped, flagged and never leak into a tile. A long seeded random mix then compares both directions every cycle against a model in the bench.

// File: rtl/conc_rr_pick.sv
module conc_rr_pick #(
  parameter int N_TILES = 6,
  localparam int SEL_W  = $clog2(N_TILES)
) (
  input  logic [N_TILES-1:0] req_i,
  input  logic [SEL_W-1:0]   ptr_i,
  output logic               found_o,
  output logic [SEL_W-1:0]   idx_o
);
  // scan downward so the lowest offset from ptr wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N_TILES - 1; k >= 0; k--) begin
      int p;
      p = (int'(ptr_i) + k) % N_TILES;
      if (req_i[p]) begin
        found_o = 1'b1;
        idx_o   = SEL_W'(p);
      end
    end
  end
endmodule

// File: rtl/conc_tx_combiner.sv
module conc_tx_combiner #(
  parameter int N_TILES = 6,
  parameter int DATA_W  = 16,
  localparam int SEL_W  = $clog2(N_TILES),
  localparam int PKT_W  = DATA_W + SEL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_TILES-1:0]          tile_valid_i,
  input  logic [N_TILES*DATA_W-1:0]   tile_data_i,
  output logic [N_TILES-1:0]          tile_ready_o,
  output logic                        pkt_valid_o,
  output logic [PKT_W-1:0]            pkt_data_o,
  input  logic                        pkt_ready_i
);
  logic [SEL_W-1:0]  ptr_q, pick;
  logic              found, load;
  logic [DATA_W-1:0] word [N_TILES];

  for (genvar t = 0; t < N_TILES; t++) begin : g_unpack
    assign word[t]         = tile_data_i[t*DATA_W +: DATA_W];
    assign tile_ready_o[t] = load && (pick == SEL_W'(t));
  end

  conc_rr_pick #(.N_TILES(N_TILES)) u_pick (
    .req_i   (tile_valid_i),
    .ptr_i   (ptr_q),
    .found_o (found),
    .idx_o   (pick)
  );

  assign load = found && (!pkt_valid_o || pkt_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pkt_valid_o <= 1'b0;
      pkt_data_o  <= '0;
      ptr_q       <= '0;
    end else if (load) begin
      pkt_valid_o <= 1'b1;
      pkt_data_o  <= {pick, word[pick]};
      ptr_q       <= (pick == SEL_W'(N_TILES - 1)) ? '0 : pick + 1'b1;
    end else if (pkt_ready_i) begin
      pkt_valid_o <= 1'b0;
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_data_o)); // R4
  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tile_ready_o) && ((tile_ready_o & ~tile_valid_i) == '0)); // R2
  AST_PTR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tile_valid_i == '0) |=> $stable(ptr_q)); // R3
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < N_TILES); // R2
  AST_SRC_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> int'(pkt_data_o[PKT_W-1 -: SEL_W]) < N_TILES); // R1
endmodule

// File: rtl/conc_rx_steer.sv
module conc_rx_steer #(
  parameter int N_TILES = 6,
  parameter int DATA_W  = 16,
  localparam int SEL_W  = $clog2(N_TILES),
  localparam int PKT_W  = DATA_W + SEL_W,
  localparam int SEL_N  = 1 << SEL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        pkt_valid_i,
  input  logic [PKT_W-1:0]            pkt_data_i,
  output logic                        pkt_ready_o,
  output logic [N_TILES-1:0]          tile_valid_o,
  output logic [N_TILES*DATA_W-1:0]   tile_data_o,
  input  logic [N_TILES-1:0]          tile_ready_i,
  output logic                        err_o
);
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] payload;
  logic              bad;
  logic [SEL_N-1:0]  free_pad;

  assign sel     = pkt_data_i[PKT_W-1 -: SEL_W];
  assign payload = pkt_data_i[DATA_W-1:0];
  assign bad     = int'(sel) >= N_TILES;

  always_comb begin
    free_pad = '0;
    free_pad[N_TILES-1:0] = ~tile_valid_o | tile_ready_i;
  end

  assign pkt_ready_o = bad || free_pad[sel];

  for (genvar t = 0; t < N_TILES; t++) begin : g_slot
    logic hit;
    assign hit = pkt_valid_i && pkt_ready_o && (sel == SEL_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tile_valid_o[t]                  <= 1'b0;
        tile_data_o[t*DATA_W +: DATA_W]  <= '0;
      end else if (hit) begin
        tile_valid_o[t]                  <= 1'b1;
        tile_data_o[t*DATA_W +: DATA_W]  <= payload;
      end else if (tile_ready_i[t]) begin
        tile_valid_o[t]                  <= 1'b0;
      end
    end

    AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tile_valid_o[t] && !tile_ready_i[t] |=>
        tile_valid_o[t] && $stable(tile_data_o[t*DATA_W +: DATA_W])); // R6
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= pkt_valid_i && bad;
  end

  AST_BAD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && bad |=> err_o && ((tile_valid_o & ~$past(tile_valid_o)) == '0)); // R7
  AST_STEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && pkt_ready_o && !bad |=> tile_valid_o[$past(sel)]); // R5
endmodule

// File: rtl/tile_port_concentrator.sv
module tile_port_concentrator #(
  parameter int N_TILES = 6,
  parameter int DATA_W  = 16,
  localparam int SEL_W  = $clog2(N_TILES),
  localparam int PKT_W  = DATA_W + SEL_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_TILES-1:0]          tile_tx_valid_i,
  input  logic [N_TILES*DATA_W-1:0]   tile_tx_data_i,
  output logic [N_TILES-1:0]          tile_tx_ready_o,
  output logic                        rtr_tx_valid_o,
  output logic [PKT_W-1:0]            rtr_tx_data_o,
  input  logic                        rtr_tx_ready_i,
  input  logic                        rtr_rx_valid_i,
  input  logic [PKT_W-1:0]            rtr_rx_data_i,
  output logic                        rtr_rx_ready_o,
  output logic [N_TILES-1:0]          tile_rx_valid_o,
  output logic [N_TILES*DATA_W-1:0]   tile_rx_data_o,
  input  logic [N_TILES-1:0]          tile_rx_ready_i,
  output logic                        err_o
);
  conc_tx_combiner #(.N_TILES(N_TILES), .DATA_W(DATA_W)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tile_valid_i (tile_tx_valid_i),
    .tile_data_i  (tile_tx_data_i),
    .tile_ready_o (tile_tx_ready_o),
    .pkt_valid_o  (rtr_tx_valid_o),
    .pkt_data_o   (rtr_tx_data_o),
    .pkt_ready_i  (rtr_tx_ready_i)
  );

  conc_rx_steer #(.N_TILES(N_TILES), .DATA_W(DATA_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pkt_valid_i  (rtr_rx_valid_i),
    .pkt_data_i   (rtr_rx_data_i),
    .pkt_ready_o  (rtr_rx_ready_o),
    .tile_valid_o (tile_rx_valid_o),
    .tile_data_o  (tile_rx_data_o),
    .tile_ready_i (tile_rx_ready_i),
    .err_o        (err_o)
  );

  AST_RST_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !rtr_tx_valid_o && (tile_rx_valid_o == '0) && !err_o); // R8
endmodule

// File: tb/sim_tile_port_concentrator.sv
`timescale 1ns/1ps
module sim_tile_port_concentrator;
  localparam int N  = 6;
  localparam int DW = 16;
  localparam int SW = $clog2(N);
  localparam int PW = DW + SW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    tv = '0, trr = '0;
  logic [N*DW-1:0] td = '0;
  logic            txr = 1'b0, rxv = 1'b0;
  logic [PW-1:0]   rxd = '0;
  logic [N-1:0]    tx_rdy, rx_v;
  logic [N*DW-1:0] rx_d;
  logic            tx_v, rx_rdy, err;
  logic [PW-1:0]   tx_d;

  tile_port_concentrator #(.N_TILES(N), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .tile_tx_valid_i(tv), .tile_tx_data_i(td), .tile_tx_ready_o(tx_rdy),
    .rtr_tx_valid_o(tx_v), .rtr_tx_data_o(tx_d), .rtr_tx_ready_i(txr),
    .rtr_rx_valid_i(rxv), .rtr_rx_data_i(rxd), .rtr_rx_ready_o(rx_rdy),
    .tile_rx_valid_o(rx_v), .tile_rx_data_o(rx_d), .tile_rx_ready_i(trr),
    .err_o(err)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  int          m_ptr = 0;
  bit          m_txv = 1'b0, m_err = 1'b0;
  logic [PW-1:0] m_txd = '0;
  bit [N-1:0]  m_rv = '0;
  logic [DW-1:0] m_rd [N];
  bit [N-1:0]  tv_hold = '0;
  bit          rx_hold = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick_first(input logic [N-1:0] req, input int ptr);
    for (int k = 0; k < N; k++) if (req[(ptr + k) % N]) return (ptr + k) % N;
    return -1;
  endfunction

  // pv: request %, pr: router ready %, prx: inbound valid %, pbad: bad select %, pt: tile ready %
  task automatic step(input int pv, input int pr, input int prx, input int pbad, input int pt);
    int g, sel;
    bit can, exp_rr;
    logic [N-1:0] exp_gr;
    @(negedge clk);
    chk(tx_v == m_txv, "R4 tx valid", 64'(tx_v), 64'(m_txv));
    if (m_txv) chk(tx_d == m_txd, "R1 tx packet", 64'(tx_d), 64'(m_txd));
    chk(rx_v == m_rv, "R5 tile valids", 64'(rx_v), 64'(m_rv));
    for (int t = 0; t < N; t++)
      if (m_rv[t]) chk(rx_d[t*DW +: DW] == m_rd[t], "R5 tile data", 64'(rx_d[t*DW +: DW]), 64'(m_rd[t]));
    chk(err == m_err, "R7 err pulse", 64'(err), 64'(m_err));

    for (int t = 0; t < N; t++) if (!tv_hold[t]) begin
      tv[t] = ($urandom % 100) < pv;
      td[t*DW +: DW] = DW'($urandom);
    end
    txr = ($urandom % 100) < pr;
    if (!rx_hold) begin
      rxv = ($urandom % 100) < prx;
      sel = (($urandom % 100) < pbad) ? N + int'($urandom % ((1 << SW) - N)) : int'($urandom % N);
      rxd = {SW'(sel), DW'($urandom)};
    end
    for (int t = 0; t < N; t++) trr[t] = ($urandom % 100) < pt;
    #1;

    can = !m_txv || txr;
    g = can ? pick_first(tv, m_ptr) : -1;
    exp_gr = (g >= 0) ? N'(1 << g) : '0;
    chk(tx_rdy == exp_gr, "R2 grant (R3 idle, R8 start)", 64'(tx_rdy), 64'(exp_gr));
    sel = int'(rxd[PW-1 -: SW]);
    exp_rr = (sel >= N) ? 1'b1 : (!m_rv[sel] || trr[sel]);
    if (rxv) chk(rx_rdy == exp_rr, "R6 router-side ready", 64'(rx_rdy), 64'(exp_rr));

    if (g >= 0) begin
      m_txv = 1'b1;
      m_txd = {SW'(g), td[g*DW +: DW]};
      m_ptr = (g + 1) % N;
    end else if (txr) m_txv = 1'b0;
    for (int t = 0; t < N; t++) if (m_rv[t] && trr[t]) m_rv[t] = 1'b0;
    if (rxv && exp_rr && sel < N) begin
      m_rv[sel] = 1'b1;
      m_rd[sel] = rxd[DW-1:0];
    end
    m_err = rxv && (sel >= N);
    for (int t = 0; t < N; t++) tv_hold[t] = tv[t] && (g != t);
    rx_hold = rxv && !exp_rr;
  endtask

  initial begin
    for (int t = 0; t < N; t++) m_rd[t] = '0;
    void'($urandom(32'h5eed_0c0d));
    repeat (3) begin
      @(negedge clk);
      chk(!tx_v && rx_v == '0 && !err, "R8 reset outputs", 64'({tx_v, rx_v, err}), 64'(0));
    end
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (40)   step(100, 100, 0, 0, 100);  // R2 full rotation, R8 start at tile 0
    repeat (30)   step(0, 100, 0, 0, 100);    // R3 idle keeps pointer
    repeat (40)   step(100, 100, 0, 0, 100);  // R3 resumes from held pointer
    repeat (200)  step(40, 20, 0, 0, 100);    // R4 router stalls
    repeat (300)  step(0, 100, 90, 0, 15);    // R6 slow tiles
    repeat (300)  step(0, 100, 80, 60, 50);   // R7 bad selects
    repeat (3000) step(50, 60, 60, 15, 60);   // R1 R5 random mix
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule